// File: doc/BRIEF.md
# Flash Busy-Toggle Status Responder

This block sits on the device side of a parallel NOR flash, between the embedded-operation sequencer and the host data bus. The sequencer tells it when a program or an erase starts, when an erase is suspended or resumed, and when an operation finishes. The block answers each host read access in one of two ways. It returns array data when the device is idle. While an internal operation runs, it returns a status word instead. In that word one bit inverts on every read access, so polling software can tell that the device is busy by reading twice and comparing.

The status bit advances once per read access, not with time. A read access starts when the chip-select and read-enable strobes are both low while write-enable is high. An erase suspend freezes the bit. A program issued while the erase is suspended makes it toggle again. Commands aimed only at protected sectors make the bit toggle for a fixed number of clock cycles and then the block falls back to array reads. Those lengths are parameters, one for programs and one for erases. For an erase that covers some protected and some open sectors, the block hands the sequencer a mask that leaves out the protected sectors.

Top module: `flash_toggle_status`

## Requirements
- R1: During a running program or erase, each read access returns a status word one cycle after the access starts. Bit TOG_BIT is the inverse of its value at the previous read, and the first read after idle gives 1. All other bits are 0.
- R2: When idle, each read access returns `array_data`, sampled at the first clock edge of the access, on `data_out` one cycle later. The toggle bit does not change.
- R3: The done command (`op_cmd`=5) ends a running operation and clears the toggle bit to 0. Later reads return array data.
- R4: The suspend command (`op_cmd`=3) during an erase freezes the toggle bit, so reads keep returning the same status word. The resume command (`op_cmd`=4) restarts toggling from the frozen value.
- R5: A program command (`op_cmd`=1) while erase is suspended toggles the bit on each read. A done command then returns to the suspended state with the bit cleared to 0.
- R6: An erase command (`op_cmd`=2) whose selected sectors are all protected gives status for T_ERASE_PROT cycles. After that, reads return array data.
- R7: A program command whose sector (the top address bits) is protected gives status for T_PROG_PROT cycles. After that, reads return array data.
- R8: On an accepted erase, `erase_eff` is loaded with `erase_sel` AND NOT `sect_prot`. It holds that value until the next accepted erase.
- R9: A read access is counted once, however long the strobes stay low. Strobe activity while `write_en_n` is low counts as no read.
- R10: A command that does not apply in the current state has no effect (for example, suspend while idle or while programming). Codes 0, 6 and 7 mean no command.
- R11: Reset clears `data_out` and `erase_eff` to 0 and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel_n | input | 1 | Active-low chip select from the host |
| read_en_n | input | 1 | Active-low output enable from the host |
| write_en_n | input | 1 | Active-low write strobe from the host |
| addr | input | ADDR_W | Host address; the top bits pick the sector |
| array_data | input | DATA_W | Data read from the array at `addr` |
| op_cmd | input | 3 | Sequencer event: 1 program, 2 erase, 3 suspend, 4 resume, 5 done |
| erase_sel | input | NUM_SECT | Sectors chosen for erase |
| sect_prot | input | NUM_SECT | Per-sector protect flags |
| data_out | output | DATA_W | Value driven on the data bus for the last read |
| erase_eff | output | NUM_SECT | Sectors the erase actually works on |

## Verification
The bench builds the block with T_PROG_PROT=7 and T_ERASE_PROT=20, four sectors and 8-bit address and data, in place of the long defaults. With these values both protected windows close within a few back-to-back reads, so the bench counts exactly how many status reads each window yields. The odd program length puts a read access on the very cycle the window expires. Sector 2 stays protected, so full, partial and absent protection all occur in one run.

// File: rtl/flash_tgl_pkg.sv
package flash_tgl_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PROG   = 3'd1,
        CMD_ERASE  = 3'd2,
        CMD_SUSP   = 3'd3,
        CMD_RESUME = 3'd4,
        CMD_DONE   = 3'd5
    } tgl_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROG      = 3'd1,
        ST_ERASE     = 3'd2,
        ST_SUSP      = 3'd3,
        ST_SUSP_PROG = 3'd4,
        ST_PROT      = 3'd5
    } tgl_state_e;

    function automatic logic is_toggling(input tgl_state_e st);
        return (st == ST_PROG) || (st == ST_ERASE) ||
               (st == ST_SUSP_PROG) || (st == ST_PROT);
    endfunction

endpackage

// File: rtl/tgl_read_edge.sv
module tgl_read_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_sel_n,
    input  logic read_en_n,
    input  logic write_en_n,
    output logic rd_edge
);
    typedef struct packed {
        logic act;
    } edge_reg_t;

    edge_reg_t cur_q, nxt_d;
    logic      act_now;

    always_comb begin
        act_now   = !chip_sel_n && !read_en_n && write_en_n;
        nxt_d     = cur_q;
        nxt_d.act = act_now;
        rd_edge   = act_now && !cur_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // One access, one count.
    p_single_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_edge |=> !rd_edge);

endmodule

// File: rtl/tgl_prot_timer.sv
module tgl_prot_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_reg_t;

    tmr_reg_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        expire = cur_q.active && (cur_q.cnt == '0);
        if (start) begin
            nxt_d.active = 1'b1;
            nxt_d.cnt    = len;
        end else if (expire) begin
            nxt_d.active = 1'b0;
        end else if (cur_q.active) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.active && !expire && !start) |=> (cur_q.cnt == $past(cur_q.cnt) - 1'b1));

    p_expire_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !expire);

endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
    import flash_tgl_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 8,
    parameter int NUM_SECT     = 4,
    parameter int TOG_BIT      = 6,
    parameter int T_PROG_PROT  = 50,
    parameter int T_ERASE_PROT = 5000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chip_sel_n,
    input  logic                read_en_n,
    input  logic                write_en_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   array_data,
    input  logic [2:0]          op_cmd,
    input  logic [NUM_SECT-1:0] erase_sel,
    input  logic [NUM_SECT-1:0] sect_prot,
    output logic [DATA_W-1:0]   data_out,
    output logic [NUM_SECT-1:0] erase_eff
);
    localparam int SEC_BITS = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
    localparam int T_MAX    = (T_ERASE_PROT > T_PROG_PROT) ? T_ERASE_PROT : T_PROG_PROT;
    localparam int CNT_W    = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] P_LEN = CNT_W'(T_PROG_PROT - 1);
    localparam logic [CNT_W-1:0] E_LEN = CNT_W'(T_ERASE_PROT - 1);
    localparam logic [DATA_W-1:0] TOG_MASK = DATA_W'(1) << TOG_BIT;

    typedef struct packed {
        tgl_state_e          state;
        logic                tog;
        logic                ret_susp;
        logic [DATA_W-1:0]   dout;
        logic [NUM_SECT-1:0] eff;
    } stat_reg_t;

    stat_reg_t           cur_q, nxt_d;
    tgl_cmd_e            cmd_e;
    logic                rd_edge;
    logic                tmr_start;
    logic [CNT_W-1:0]    tmr_len;
    logic                tmr_expire;
    logic [SEC_BITS-1:0] prog_sec;
    logic                prog_prot;
    logic [NUM_SECT-1:0] eff_w;
    logic                addr_lo_unused;

    function automatic logic [DATA_W-1:0] stat_word(input logic b);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[TOG_BIT] = b;
        return w;
    endfunction

    tgl_read_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel_n (chip_sel_n),
        .read_en_n  (read_en_n),
        .write_en_n (write_en_n),
        .rd_edge    (rd_edge)
    );

    tgl_prot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .len    (tmr_len),
        .expire (tmr_expire)
    );

    generate
        if (ADDR_W > SEC_BITS) begin : g_addr_split
            assign addr_lo_unused = ^addr[ADDR_W-SEC_BITS-1:0];
        end else begin : g_addr_all
            assign addr_lo_unused = 1'b0;
        end
    endgenerate

    assign prog_sec  = addr[ADDR_W-1 -: SEC_BITS];
    assign prog_prot = sect_prot[prog_sec];
    assign eff_w     = erase_sel & ~sect_prot;
    assign cmd_e     = (op_cmd <= 3'd5) ? tgl_cmd_e'(op_cmd) : CMD_NONE;

    always_comb begin
        nxt_d     = cur_q;
        tmr_start = 1'b0;
        tmr_len   = P_LEN;

        // Read response, decided by the state at the start of the access.
        if (rd_edge) begin
            if (is_toggling(cur_q.state)) begin
                nxt_d.tog  = ~cur_q.tog;
                nxt_d.dout = stat_word(~cur_q.tog);
            end else if (cur_q.state == ST_SUSP) begin
                nxt_d.dout = stat_word(cur_q.tog);
            end else begin
                nxt_d.dout = array_data;
            end
        end

        case (cur_q.state)
            ST_IDLE: begin
                if (cmd_e == CMD_PROG) begin
                    if (prog_prot) begin
                        nxt_d.state    = ST_PROT;
                        nxt_d.ret_susp = 1'b0;
                        tmr_start      = 1'b1;
                        tmr_len        = P_LEN;
                    end else begin
                        nxt_d.state = ST_PROG;
                    end
                end else if (cmd_e == CMD_ERASE && (|erase_sel)) begin
                    nxt_d.eff = eff_w;
                    if (eff_w == '0) begin
                        nxt_d.state    = ST_PROT;
                        nxt_d.ret_susp = 1'b0;
                        tmr_start      = 1'b1;
                        tmr_len        = E_LEN;
                    end else begin
                        nxt_d.state = ST_ERASE;
                    end
                end
            end
            ST_PROG: begin
                if (cmd_e == CMD_DONE) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.tog   = 1'b0;
                end
            end
            ST_ERASE: begin
                if (cmd_e == CMD_DONE) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.tog   = 1'b0;
                end else if (cmd_e == CMD_SUSP) begin
                    nxt_d.state = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (cmd_e == CMD_PROG) begin
                    if (prog_prot) begin
                        nxt_d.state    = ST_PROT;
                        nxt_d.ret_susp = 1'b1;
                        tmr_start      = 1'b1;
                        tmr_len        = P_LEN;
                    end else begin
                        nxt_d.state = ST_SUSP_PROG;
                    end
                end else if (cmd_e == CMD_RESUME) begin
                    nxt_d.state = ST_ERASE;
                end
            end
            ST_SUSP_PROG: begin
                if (cmd_e == CMD_DONE) begin
                    nxt_d.state = ST_SUSP;
                    nxt_d.tog   = 1'b0;
                end
            end
            ST_PROT: begin
                if (tmr_expire) begin
                    nxt_d.state    = cur_q.ret_susp ? ST_SUSP : ST_IDLE;
                    nxt_d.ret_susp = 1'b0;
                    nxt_d.tog      = 1'b0;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign data_out  = cur_q.dout;
    assign erase_eff = cur_q.eff;

    p_flip_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_edge && is_toggling(cur_q.state)) |=> (data_out[TOG_BIT] != $past(cur_q.tog)));

    p_status_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_edge && cur_q.state != ST_IDLE) |=> ((data_out & ~TOG_MASK) == '0));

    p_idle_array_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_edge && cur_q.state == ST_IDLE) |=> (data_out == $past(array_data)));

    p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_PROG && cmd_e == CMD_DONE) |=> (!cur_q.tog && cur_q.state == ST_IDLE));

    p_susp_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_SUSP && cmd_e != CMD_PROG && cmd_e != CMD_RESUME) |=> $stable(cur_q.tog));

    p_partial_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE && cmd_e == CMD_ERASE && (|erase_sel))
            |=> (erase_eff == $past(erase_sel & ~sect_prot)));

endmodule

// File: tb/flash_toggle_status_tb_top.sv
`timescale 1ns/1ps
module flash_toggle_status_tb_top;

    localparam int DW   = 8;
    localparam int AW   = 8;
    localparam int NS   = 4;
    localparam int TP   = 7;
    localparam int TE   = 20;
    localparam logic [7:0] XORK = 8'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel_n = 1'b1;
    logic          read_en_n = 1'b1;
    logic          write_en_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] array_data;
    logic [2:0]    op_cmd = 3'd0;
    logic [NS-1:0] erase_sel = '0;
    logic [NS-1:0] sect_prot = 4'b0100;
    logic [DW-1:0] data_out;
    logic [NS-1:0] erase_eff;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    assign array_data = addr ^ XORK;

    flash_toggle_status #(
        .DATA_W(DW), .ADDR_W(AW), .NUM_SECT(NS), .TOG_BIT(6),
        .T_PROG_PROT(TP), .T_ERASE_PROT(TE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .read_en_n(read_en_n),
        .write_en_n(write_en_n), .addr(addr), .array_data(array_data), .op_cmd(op_cmd),
        .erase_sel(erase_sel), .sect_prot(sect_prot), .data_out(data_out), .erase_eff(erase_eff)
    );

    // Fields: req[27:24] op[23:20] sel[19:16] addr[15:8] expected[7:0]; op 6 = read.
    localparam int NV = 27;
    localparam logic [27:0] VEC [NV] = '{
        28'h2_6_0_10_2C,  // R2 idle read
        28'h2_6_0_20_1C,  // R2
        28'h1_1_0_05_00,  // R1 program sector 0
        28'h1_6_0_00_40,  // R1
        28'h1_6_0_33_00,  // R1
        28'h1_6_0_C1_40,  // R1
        28'h3_5_0_00_00,  // R3 done
        28'h3_6_0_10_2C,  // R3
        28'h8_2_3_00_00,  // R8 erase sectors 0,1
        28'h4_6_3_00_40,  // R4
        28'h4_6_3_00_00,  // R4
        28'h4_6_3_00_40,  // R4
        28'h4_3_3_00_00,  // R4 suspend
        28'h4_6_3_00_40,  // R4 frozen
        28'h4_6_3_11_40,  // R4 frozen
        28'h5_1_3_45_00,  // R5 program in suspend
        28'h5_6_3_00_00,  // R5
        28'h5_6_3_00_40,  // R5
        28'h5_5_3_00_00,  // R5 done back to suspend
        28'h5_6_3_00_00,  // R5
        28'h4_4_3_00_00,  // R4 resume
        28'h4_6_3_00_40,  // R4
        28'h4_6_3_00_00,  // R4
        28'h3_5_3_00_00,  // R3 done
        28'h3_6_3_50_6C,  // R3
        28'hA_3_0_00_00,  // R10 suspend while idle
        28'hA_6_0_50_6C   // R10
    };

    task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] c, input logic [7:0] a);
        op_cmd = c; addr = a;
        @(negedge clk);
        op_cmd = 3'd0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input int req);
        addr = a; chip_sel_n = 1'b0; read_en_n = 1'b0;
        @(negedge clk);
        chk(req, data_out, exp);
        chip_sel_n = 1'b1; read_en_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(11, data_out, 8'h00);
        chk(11, {4'h0, erase_eff}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            erase_sel = VEC[i][19:16];
            if (VEC[i][23:20] == 4'd6)
                do_read(VEC[i][15:8], VEC[i][7:0], int'(VEC[i][27:24]));
            else
                do_cmd(VEC[i][22:20], VEC[i][15:8]);
        end

        // R8 partial protection: sectors 1,2 selected, 2 protected
        erase_sel = 4'b0110;
        do_cmd(3'd2, 8'h00);
        chk(8, {4'h0, erase_eff}, 8'h02);
        do_read(8'h00, 8'h40, 8);
        do_cmd(3'd5, 8'h00);

        // R6 all selected sectors protected: TE cycles of status
        erase_sel = 4'b0100;
        do_cmd(3'd2, 8'h00);
        chk(6, {4'h0, erase_eff}, 8'h00);
        for (int k = 0; k < (TE + 1) / 2; k++)
            do_read(8'h00, (k % 2 == 0) ? 8'h40 : 8'h00, 6);
        do_read(8'h00, 8'h3C, 6);

        // R7 program to protected sector 2: TP cycles, read on expiry cycle
        do_cmd(3'd1, 8'h80);
        for (int k = 0; k < (TP + 1) / 2; k++)
            do_read(8'h80, (k % 2 == 0) ? 8'h40 : 8'h00, 7);
        do_read(8'h80, 8'hBC, 7);

        // R10 suspend during program ignored
        do_cmd(3'd1, 8'h05);
        do_cmd(3'd3, 8'h00);
        do_read(8'h00, 8'h40, 10);
        do_read(8'h00, 8'h00, 10);

        // R9 write strobe counts as no read; long read counts once
        do_read(8'h00, 8'h40, 9);
        chip_sel_n = 1'b0; read_en_n = 1'b0; write_en_n = 1'b0;
        repeat (2) @(negedge clk);
        chip_sel_n = 1'b1; read_en_n = 1'b1; write_en_n = 1'b1;
        @(negedge clk);
        chk(9, data_out, 8'h40);
        chip_sel_n = 1'b0; read_en_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(9, data_out, 8'h00);
        chip_sel_n = 1'b1; read_en_n = 1'b1;
        @(negedge clk);
        do_read(8'h00, 8'h40, 9);

        // R11 reset during busy
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(11, data_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(8'h10, 8'h2C, 11);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule